// File: doc/BRIEF.md
# Three-LED Status Indicator Driver

This block turns a handful of PHY status signals into drive levels for three indicator LEDs: a link lamp, a speed lamp and an activity lamp. A two-bit configuration value, held in a control register elsewhere, picks one of three mappings. The mapping decides what the activity lamp shows and whether the link lamp also blinks to signal traffic.

Activity arrives as single-clock pulses, which would be invisible on a lamp. A stretch counter holds each pulse for a minimum on-time. A divider, restarted whenever link comes up, supplies the blink phase. Losing link clears both counters, so no stale activity or blink phase carries over into the next link-up.

All three outputs are registered. Every output therefore reflects the inputs sampled at the previous rising clock edge.

Top module: `led_status_drv`

## Requirements
- R1: Mode decode uses `led_cfg`. If `led_cfg[0]`=1 the mode is "link/activity" and `led_cfg[1]` has no effect. `led_cfg`=2'b00 selects "collision". `led_cfg`=2'b10 selects "duplex".
- R2: In every mode, `led_speed` equals the `speed100` value sampled at the previous clock edge.
- R3: `led_link` is 0 in the cycle after any edge at which `link_ok` is 0, even if activity is present.
- R4: In link/activity mode, `led_link` equals the `link_ok` value sampled at the previous edge.
- R5: In link/activity mode, `led_act` comes on at the edge that samples `act_pulse`=1 with link good. It stays on for STRETCH_CYCLES edges counted from the most recent such pulse, and a new pulse restarts that window.
- R6: In collision and duplex modes with link good, `led_link` is steady on when activity is not visible. While activity is visible (as defined in R5), it follows the blink phase. That phase is on for the first BLINK_HALF edges counted from the first edge with link good, then alternates every BLINK_HALF edges.
- R7: In collision mode, `led_act` equals `col` sampled at the previous edge.
- R8: In duplex mode, `led_act` equals `fdx` sampled at the previous edge.
- R9: An edge with `link_ok`=0 cancels any pending activity stretch. After link returns, activity shows only for new pulses, and the blink phase restarts in its on half.
- R10: While `rst_n` is 0 at an edge, all three outputs are 0 after that edge. Counters restart as if link had dropped.
- R11: A change of `led_cfg` takes effect at the first edge that samples the new value, with no intermediate output pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| led_cfg | input | 2 | Mode selection bits from the control register |
| link_ok | input | 1 | Link is good |
| speed100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| act_pulse | input | 1 | One-clock activity indication |
| col | input | 1 | Collision present |
| fdx | input | 1 | 1 = full duplex, 0 = half duplex |
| led_link | output | 1 | Link lamp drive, 1 = on |
| led_speed | output | 1 | Speed lamp drive, 1 = on |
| led_act | output | 1 | Activity/collision/duplex lamp drive, 1 = on |

## Verification
The bench builds the block with STRETCH_CYCLES=5 and BLINK_HALF=3. At these values a pulse expires, or is retriggered, within a handful of cycles, and several full blink periods fit between random link drops. A few hundred pseudo-random cycles per `led_cfg` value therefore reach every mode, including the ignored `led_cfg[1]` in link/activity mode. They also reach stretch windows that are cut short by link loss and blink phases that restart on link return. Directed sequences add link loss in the middle of a stretch, continuous traffic across many blink periods, and mode changes on consecutive cycles.

// File: rtl/led_pkg.sv
// Shared types for the LED status driver.
// Assumes: nothing beyond IEEE 1800-2017.
package led_pkg;

    typedef enum logic [1:0] {
        LED_MODE_LINKACT   = 2'd0,
        LED_MODE_COLLISION = 2'd1,
        LED_MODE_DUPLEX    = 2'd2
    } led_mode_e;

endpackage

// File: rtl/led_mode_dec.sv
// Decodes the two configuration bits into one of three lamp mappings.
// Assumes: cfg[0]=1 selects link/activity whatever cfg[1] is.
module led_mode_dec
    import led_pkg::*;
(
    input  logic [1:0] cfg,
    output led_mode_e  mode
);

    // Priority decode: bit 0 wins, then bit 1 picks duplex or collision.
    always_comb begin
        if (cfg[0]) begin
            mode = LED_MODE_LINKACT;
        end else if (cfg[1]) begin
            mode = LED_MODE_DUPLEX;
        end else begin
            mode = LED_MODE_COLLISION;
        end
    end

endmodule

// File: rtl/led_act_stretch.sv
// Stretches one-clock activity pulses to a minimum visible on-time.
// act_vis is high in the pulse cycle and for STRETCH_CYCLES-1 cycles after.
// Assumes: STRETCH_CYCLES >= 1; link loss cancels any pending stretch.
module led_act_stretch #(
    parameter int STRETCH_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic act_pulse,
    output logic act_vis
);

    localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_CYCLES - 1);

    logic [CNT_W-1:0] remain_q;

    // Remaining hold cycles: reload on pulse, count down, clear on link loss.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_ok) begin
            remain_q <= '0;
        end else if (act_pulse) begin
            remain_q <= RELOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Visible while a pulse is present now or the hold has not run out.
    assign act_vis = link_ok & (act_pulse | (remain_q != '0));

endmodule

// File: rtl/led_blink_gen.sv
// Free-running blink phase generator with a half-period of BLINK_HALF cycles.
// Phase starts "on" and is held there while link is down or in reset.
// Assumes: BLINK_HALF >= 1.
module led_blink_gen #(
    parameter int BLINK_HALF = 6_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    output logic blink_on
);

    localparam int CNT_W = $clog2(BLINK_HALF + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_HALF - 1);

    logic [CNT_W-1:0] div_q;
    logic             phase_q;

    // Divider and phase toggle; restart in the on phase when link is absent.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_ok) begin
            div_q   <= '0;
            phase_q <= 1'b1;
        end else if (div_q == LAST) begin
            div_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            div_q <= div_q + CNT_W'(1);
        end
    end

    assign blink_on = phase_q;

endmodule

// File: rtl/led_status_drv.sv
// Top of the three-lamp status driver. Combines mode decode, activity
// stretch and blink phase into registered lamp levels (1 = lamp on).
// Assumes: status inputs are synchronous to clk; pad polarity is handled
// outside this block.
module led_status_drv
    import led_pkg::*;
#(
    parameter int STRETCH_CYCLES = 12_500_000,
    parameter int BLINK_HALF     = 6_250_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] led_cfg,
    input  logic       link_ok,
    input  logic       speed100,
    input  logic       act_pulse,
    input  logic       col,
    input  logic       fdx,
    output logic       led_link,
    output logic       led_speed,
    output logic       led_act
);

    led_mode_e mode;
    logic      act_vis;
    logic      blink_on;
    logic      link_nxt;
    logic      act_nxt;

    led_mode_dec u_dec (
        .cfg  (led_cfg),
        .mode (mode)
    );

    led_act_stretch #(
        .STRETCH_CYCLES (STRETCH_CYCLES)
    ) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_ok   (link_ok),
        .act_pulse (act_pulse),
        .act_vis   (act_vis)
    );

    led_blink_gen #(
        .BLINK_HALF (BLINK_HALF)
    ) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_ok  (link_ok),
        .blink_on (blink_on)
    );

    // Next lamp levels selected by the decoded mode.
    always_comb begin
        case (mode)
            LED_MODE_LINKACT: begin
                link_nxt = link_ok;
                act_nxt  = act_vis;
            end
            LED_MODE_COLLISION: begin
                link_nxt = link_ok & (~act_vis | blink_on);
                act_nxt  = col;
            end
            default: begin
                link_nxt = link_ok & (~act_vis | blink_on);
                act_nxt  = fdx;
            end
        endcase
    end

    // Output registers: glitch-free lamp levels, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_link  <= 1'b0;
            led_speed <= 1'b0;
            led_act   <= 1'b0;
        end else begin
            led_link  <= link_nxt;
            led_speed <= speed100;
            led_act   <= act_nxt;
        end
    end

endmodule

// File: rtl/led_status_drv_chk.sv
// Property checker for led_status_drv, attached through bind.
// Assumes: same clock and reset as the block it watches.
module led_status_drv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] led_cfg,
    input logic       link_ok,
    input logic       speed100,
    input logic       act_pulse,
    input logic       col,
    input logic       fdx,
    input logic       led_link,
    input logic       led_speed,
    input logic       led_act
);

    // R10
    reset_dark_chk: assert property (@(posedge clk)
        !rst_n |=> (!led_link && !led_speed && !led_act));

    // R3
    link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok |=> !led_link);

    // R2
    speed_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (led_speed == $past(speed100)));

    // R4
    linkact_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led_cfg[0] |=> (led_link == $past(link_ok)));

    // R5
    pulse_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_cfg[0] && link_ok && act_pulse) |=> led_act);

    // R7
    col_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_cfg == 2'b00) |=> (led_act == $past(col)));

    // R8
    fdx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_cfg == 2'b10) |=> (led_act == $past(fdx)));

endmodule

bind led_status_drv led_status_drv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .led_cfg   (led_cfg),
    .link_ok   (link_ok),
    .speed100  (speed100),
    .act_pulse (act_pulse),
    .col       (col),
    .fdx       (fdx),
    .led_link  (led_link),
    .led_speed (led_speed),
    .led_act   (led_act)
);

// File: tb/led_status_drv_tb_top.sv
// Self-checking bench: small counters, pseudo-random sweeps over every
// configuration value plus directed sequences, arithmetic expected values.
module led_status_drv_tb_top;

    localparam int NS = 5;   // stretch cycles
    localparam int NB = 3;   // blink half-period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] led_cfg = 2'b01;
    logic       link_ok = 1'b0;
    logic       speed100 = 1'b0;
    logic       act_pulse = 1'b0;
    logic       col = 1'b0;
    logic       fdx = 1'b0;
    logic       led_link;
    logic       led_speed;
    logic       led_act;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference state, all in edges.
    int edge_no = 0;
    int last_pulse = -1000;
    int link_start = 0;
    bit link_prev = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;  // 250 MHz

    led_status_drv #(
        .STRETCH_CYCLES (NS),
        .BLINK_HALF     (NB)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .led_cfg   (led_cfg),
        .link_ok   (link_ok),
        .speed100  (speed100),
        .act_pulse (act_pulse),
        .col       (col),
        .fdx       (fdx),
        .led_link  (led_link),
        .led_speed (led_speed),
        .led_act   (led_act)
    );

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Drive one cycle, advance past the edge, update the model and compare.
    task automatic cyc(input bit r, input logic [1:0] c, input bit l,
                       input bit s, input bit a, input bit cl, input bit f,
                       input string tag);
        bit vis;
        bit bon;
        bit e_link;
        bit e_act;
        string tl;
        string ta;
        rst_n = r; led_cfg = c; link_ok = l; speed100 = s;
        act_pulse = a; col = cl; fdx = f;
        @(posedge clk);
        #1;
        edge_no++;
        if (!r) begin
            last_pulse = -1000;
            link_prev = 1'b0;
            check1("R10 link", led_link, 1'b0);
            check1("R10 speed", led_speed, 1'b0);
            check1("R10 act", led_act, 1'b0);
            return;
        end
        if (!l) begin
            last_pulse = -1000;
            link_prev = 1'b0;
        end else begin
            if (!link_prev) link_start = edge_no;
            link_prev = 1'b1;
            if (a) last_pulse = edge_no;
        end
        vis = l && ((edge_no - last_pulse) < NS);
        bon = (((edge_no - link_start) / NB) % 2) == 0;
        if (c[0]) begin
            e_link = l;
            e_act = vis;
            tl = l ? "R4" : "R3";
            ta = "R5";
        end else begin
            e_link = l && (!vis || bon);
            e_act = c[1] ? f : cl;
            tl = l ? "R6" : "R3";
            ta = c[1] ? "R8" : "R7";
        end
        if (c == 2'b11) ta = "R1";
        if (tag != "") begin
            tl = tag;
            ta = tag;
        end
        check1(tl, led_link, e_link);
        check1("R2", led_speed, s);
        check1(ta, led_act, e_act);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        // R10: reset holds every lamp dark even with active inputs
        for (int i = 0; i < 4; i++) cyc(1'b0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "");

        // Near-exhaustive sweep: all four configuration values, random status
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 300; i++) begin
                step_lfsr();
                cyc(1'b1, 2'(c), (lfsr[3:1] != 3'b000), lfsr[4],
                    (lfsr[7:5] == 3'b101), lfsr[8], lfsr[9], "");
            end
        end

        // R9: link loss mid-stretch, then return without a new pulse
        cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        cyc(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        for (int i = 0; i < 6; i++) cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");

        // R5: retrigger extends the window
        cyc(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 3; i++) cyc(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        cyc(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 7; i++) cyc(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");

        // R6 + R9: link return restarts blink phase, continuous traffic
        cyc(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        for (int i = 0; i < 20; i++) cyc(1'b1, 2'b00, 1'b1, 1'b0, (i % 2 == 0), 1'b0, 1'b0, "R6");
        for (int i = 0; i < 8; i++) cyc(1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6");

        // R11: mode changes on consecutive cycles
        cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        cyc(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R11");
        cyc(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R11");
        cyc(1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
        cyc(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R11");

        // R10: reset in the middle of traffic
        cyc(1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "");
        for (int i = 0; i < 6; i++) cyc(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule